// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Sequencer

This block keeps a table of transmit and receive buffer descriptors in a small word-addressed memory. The table is split by a programmable count. The first entries form the transmit ring and the remaining entries form the receive ring. Each descriptor is two 32-bit words: a status/control word followed by a buffer address word.

The sequencer walks each ring on its own. It offers the current transmit buffer to a frame engine through a request/done handshake. It offers the current empty receive buffer through a ready/done handshake. When a frame completes, it writes the outcome into the descriptor, hands ownership back to software and raises interrupt-source bits. A host port gives word reads and writes to the descriptor table, the transmit-count register, and the interrupt source and mask registers.

Top module: `eth_bd_seq`

## Requirements
- R1: Host byte addresses are fixed. 0x000 is the interrupt source register, 0x004 is the mask register (bits 6:0) and 0x008 is the transmit count register. Descriptor k has its status word at 0x400+8k and its address word at 0x404+8k. Any other address reads as 0.
- R2: The transmit count resets to 64. A written value above 128 is stored as 128. Transmit descriptors are entries 0 to N-1 and receive descriptors are entries N to 127.
- R3: With tx_en high, when the current transmit descriptor has bit 15 (ready) set, tx_req rises and presents the address word on tx_addr and status bits 31:16 on tx_len. If bit 15 is clear, the sequencer waits on that entry and never moves on to a later one.
- R4: On tx_done while tx_req is high, the status word gets bit 15 cleared and bits 8:0 replaced by tx_stat. Bits 31:16 and 14:9 are kept. tx_req then drops for at least one cycle.
- R5: After a completion, the ring pointer moves to the first entry of its ring if the descriptor has bit 13 (wrap) set or is the last entry of the ring. Otherwise it moves to the next entry.
- R6: With rx_en high, rx_rdy is high when the current receive descriptor has bit 15 (empty) set, and rx_addr shows its address word. On rx_done with rx_rdy high, the status word becomes {rx_len, 0, old bits 14:9, rx_stat}.
- R7: An rx_done while rx_en is high and rx_rdy is low sets source bit 4. It leaves the descriptor and the receive pointer unchanged.
- R8: A transmit completion of a descriptor with bit 14 set raises source bit 1 if any of tx_stat bits 0, 2, 3 or 8 is set, and source bit 0 otherwise. With bit 14 clear it raises nothing.
- R9: A receive completion of a descriptor with bit 14 set raises source bit 3 if any of rx_stat bits 6:0 is set, and source bit 2 otherwise. It also raises source bit 6 if rx_stat bit 8 is set.
- R10: A tx_ctl_done pulse sets source bit 5.
- R11: Writing a 1 to a source bit clears it. A bit being set in the same cycle stays set. irq is the OR of the source bits ANDed with the mask.
- R12: While tx_en (rx_en) is low, the transmit (receive) pointer returns to the first entry of its ring and tx_req (rx_rdy) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit ring enable |
| rx_en | input | 1 | Receive ring enable |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| tx_req | output | 1 | Transmit buffer offered to the frame engine |
| tx_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_done | input | 1 | Transmit frame finished |
| tx_stat | input | 9 | Transmit outcome bits for writeback |
| tx_ctl_done | input | 1 | Transmit control frame finished |
| rx_rdy | output | 1 | Empty receive buffer available |
| rx_addr | output | 32 | Receive buffer address |
| rx_done | input | 1 | Receive frame finished |
| rx_len | input | 16 | Received length, CRC included |
| rx_stat | input | 9 | Receive outcome bits for writeback |
| irq | output | 1 | Interrupt request |

## Verification
Transmit completions use random outcome bits, lengths, interrupt-request flags and wrap flags. This separates the error interrupt from the frame interrupt and shows that status bits are replaced while kept fields survive. Random wrap flags on a four-entry ring distinguish wrapping by flag from wrapping at the ring end. Receive completions with random outcome bits separate the error, frame and control-frame interrupts.

Directed cases cover the following:
- a ready descriptor placed behind one that is not ready, which exposes any skipping ahead;
- a frame arriving with no empty buffer;
- a count write above the limit;
- a clear racing a set on the same source bit;
- a zero mask;
- dropping an enable while the pointer is mid-ring.

// File: rtl/eth_bd_seq.sv
module eth_bd_seq #(
  parameter int NUM_BD  = 128,
  parameter int ADDR_W  = 12,
  parameter int TXN_RST = NUM_BD / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              tx_req,
  output logic [31:0]       tx_addr,
  output logic [15:0]       tx_len,
  input  logic              tx_done,
  input  logic [8:0]        tx_stat,
  input  logic              tx_ctl_done,
  output logic              rx_rdy,
  output logic [31:0]       rx_addr,
  input  logic              rx_done,
  input  logic [15:0]       rx_len,
  input  logic [8:0]        rx_stat,
  output logic              irq
);
  localparam int IDX_W   = $clog2(NUM_BD);
  localparam int CNT_W   = IDX_W + 1;
  localparam int WORDS   = 2 * NUM_BD;
  localparam int BD_BASE = 'h400;
  localparam int BD_END  = BD_BASE + 8 * NUM_BD;
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TXN  = ADDR_W'(8);

  logic [31:0]      mem [WORDS];
  logic [6:0]       src_q, mask_q, src_set, src_clr;
  logic [CNT_W-1:0] txn_q, txn_new, rx_sum;
  logic [IDX_W-1:0] tx_ptr, rx_off, rx_bd;
  logic             tx_busy;

  logic              bd_hit;
  logic [ADDR_W-1:0] bd_off;
  logic [CNT_W-1:0]  host_widx;
  assign bd_hit    = (32'(host_addr) >= 32'(BD_BASE)) && (32'(host_addr) < 32'(BD_END));
  assign bd_off    = host_addr - ADDR_W'(BD_BASE);
  assign host_widx = bd_off[CNT_W+1:2];

  logic txn_wr;
  assign txn_wr  = host_we && (host_addr == A_TXN);
  assign txn_new = (host_wdata > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : host_wdata[CNT_W-1:0];

  logic [31:0] tx_word, rx_word;
  logic        tx_has, rx_has, tx_wrap, rx_wrap, tx_fin, rx_fin, tx_err, rx_err;
  assign tx_word = mem[{tx_ptr, 1'b0}];
  assign tx_addr = mem[{tx_ptr, 1'b1}];
  assign tx_len  = tx_word[31:16];
  assign tx_has  = txn_q != '0;
  assign tx_req  = tx_busy & tx_en;
  assign tx_wrap = tx_word[13] | ({1'b0, tx_ptr} == txn_q - 1'b1);
  assign tx_fin  = tx_req & tx_done;
  assign tx_err  = tx_stat[8] | tx_stat[3] | tx_stat[2] | tx_stat[0];

  assign rx_sum  = txn_q + CNT_W'(rx_off);
  assign rx_bd   = rx_sum[IDX_W-1:0];
  assign rx_word = mem[{rx_bd, 1'b0}];
  assign rx_addr = mem[{rx_bd, 1'b1}];
  assign rx_has  = txn_q < CNT_W'(NUM_BD);
  assign rx_rdy  = rx_en & rx_has & rx_word[15];
  assign rx_wrap = rx_word[13] | (rx_sum == CNT_W'(NUM_BD - 1));
  assign rx_fin  = rx_rdy & rx_done;
  assign rx_err  = |rx_stat[6:0];

  assign src_set[0] = tx_fin & tx_word[14] & ~tx_err;
  assign src_set[1] = tx_fin & tx_word[14] & tx_err;
  assign src_set[2] = rx_fin & rx_word[14] & ~rx_err;
  assign src_set[3] = rx_fin & rx_word[14] & rx_err;
  assign src_set[4] = rx_en & rx_done & ~rx_rdy;
  assign src_set[5] = tx_ctl_done;
  assign src_set[6] = rx_fin & rx_word[14] & rx_stat[8];
  assign src_clr    = (host_we && host_addr == A_SRC) ? host_wdata[6:0] : 7'd0;
  assign irq        = |(src_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      src_q   <= '0;
      mask_q  <= '0;
      txn_q   <= CNT_W'(TXN_RST);
      tx_ptr  <= '0;
      rx_off  <= '0;
      tx_busy <= 1'b0;
    end else begin
      src_q <= (src_q & ~src_clr) | src_set;
      if (host_we && host_addr == A_MASK) mask_q <= host_wdata[6:0];
      if (host_we && bd_hit) mem[host_widx] <= host_wdata;

      if (!tx_en) begin
        tx_ptr  <= '0;
        tx_busy <= 1'b0;
      end else if (tx_busy) begin
        if (tx_done) begin
          mem[{tx_ptr, 1'b0}] <= {tx_word[31:16], 1'b0, tx_word[14:9], tx_stat};
          tx_busy <= 1'b0;
          tx_ptr  <= tx_wrap ? '0 : tx_ptr + 1'b1;
        end
      end else if (tx_has && tx_word[15]) begin
        tx_busy <= 1'b1;
      end

      if (!rx_en) begin
        rx_off <= '0;
      end else if (rx_fin) begin
        mem[{rx_bd, 1'b0}] <= {rx_len, 1'b0, rx_word[14:9], rx_stat};
        rx_off <= rx_wrap ? '0 : rx_off + 1'b1;
      end

      if (txn_wr) begin
        txn_q   <= txn_new;
        tx_ptr  <= '0;
        rx_off  <= '0;
        tx_busy <= 1'b0;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (bd_hit) host_rdata = mem[host_widx];
    else begin
      case (host_addr)
        A_SRC:   host_rdata = {25'd0, src_q};
        A_MASK:  host_rdata = {25'd0, mask_q};
        A_TXN:   host_rdata = 32'(txn_q);
        default: host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/eth_bd_seq_chk.sv
module eth_bd_seq_chk #(
  parameter int NUM_BD = 128,
  parameter int ADDR_W = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tx_en,
  input logic                       tx_req,
  input logic                       tx_done,
  input logic                       rx_en,
  input logic                       rx_rdy,
  input logic                       rx_done,
  input logic                       host_we,
  input logic [ADDR_W-1:0]          host_addr,
  input logic [31:0]                host_wdata,
  input logic                       irq,
  input logic [6:0]                 src_q,
  input logic [$clog2(NUM_BD)-1:0]  tx_ptr,
  input logic [$clog2(NUM_BD):0]    txn_q
);
  // R12
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_req);

  // R4
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_done) |=> !tx_req);

  // R7
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_done && !rx_rdy) |=> src_q[4]);

  // R11
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == ADDR_W'(4) && host_wdata[6:0] == 7'd0) |=> !irq);

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_q != '0) |-> ({1'b0, tx_ptr} < txn_q));
endmodule

bind eth_bd_seq eth_bd_seq_chk #(.NUM_BD(NUM_BD), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_req(tx_req), .tx_done(tx_done),
  .rx_en(rx_en), .rx_rdy(rx_rdy), .rx_done(rx_done), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .irq(irq), .src_q(src_q),
  .tx_ptr(tx_ptr), .txn_q(txn_q)
);

// File: tb/tb_eth_bd_seq.sv
`timescale 1ns/1ps
module tb_eth_bd_seq;
  localparam int TN = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tx_en = 0, rx_en = 0, host_we = 0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        tx_req, rx_rdy, irq;
  logic [31:0] tx_addr, rx_addr;
  logic [15:0] tx_len;
  logic        tx_done = 0, tx_ctl_done = 0, rx_done = 0;
  logic [8:0]  tx_stat = '0, rx_stat = '0;
  logic [15:0] rx_len = '0;

  int checks = 0, fails = 0;
  logic [31:0] m_st [8];
  logic [31:0] m_ad [8];
  int mtx = 0, mrx = TN;
  logic [31:0] rv;

  always #2 clk = ~clk;

  eth_bd_seq dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_done(tx_done),
    .tx_stat(tx_stat), .tx_ctl_done(tx_ctl_done), .rx_rdy(rx_rdy), .rx_addr(rx_addr),
    .rx_done(rx_done), .rx_len(rx_len), .rx_stat(rx_stat), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    host_we = 1; host_addr = a; host_wdata = d;
    cyc();
    host_we = 0; host_addr = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    host_addr = a; #1; d = host_rdata; host_addr = '0;
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] w, input logic [15:0] len, input logic [8:0] s);
    return {len, 1'b0, w[14:9], s};
  endfunction

  function automatic logic [6:0] exp_tx_src(input logic [31:0] w, input logic [8:0] s);
    if (!w[14]) return 7'd0;
    return (s[8] | s[3] | s[2] | s[0]) ? 7'h02 : 7'h01;
  endfunction

  function automatic logic [6:0] exp_rx_src(input logic [31:0] w, input logic [8:0] s);
    logic [6:0] v;
    if (!w[14]) return 7'd0;
    v = (|s[6:0]) ? 7'h08 : 7'h04;
    if (s[8]) v = v | 7'h40;
    return v;
  endfunction

  task automatic wset(input int i, input logic [31:0] st);
    m_st[i] = st;
    wr(12'h400 + 12'(8 * i), st);
  endtask

  task automatic arm_tx(input int i);
    logic [31:0] st;
    st = $urandom;
    st[15] = 1'b1;
    st[14] = ($urandom % 4) != 0;
    st[13] = ($urandom % 4) == 0;
    wset(i, st);
  endtask

  task automatic arm_rx(input int i);
    logic [31:0] st;
    st = 32'h0000_8000;
    st[14] = ($urandom % 4) != 0;
    st[13] = (i == TN + 2);
    wset(i, st);
  endtask

  task automatic do_tx();
    logic [8:0] s;
    logic [6:0] es;
    for (int k = 0; k < 10 && !tx_req; k++) cyc();
    chk("R3 tx_req", 32'(tx_req), 32'd1);
    chk("R5 tx_addr", tx_addr, m_ad[mtx]);
    chk("R3 tx_len", 32'(tx_len), 32'(m_st[mtx][31:16]));
    s = 9'($urandom);
    tx_stat = s; tx_done = 1;
    cyc();
    tx_done = 0;
    rd(12'h400 + 12'(8 * mtx), rv);
    chk("R4 tx writeback", rv, exp_word(m_st[mtx], m_st[mtx][31:16], s));
    es = exp_tx_src(m_st[mtx], s);
    rd(12'h000, rv);
    chk("R8 tx source", rv, 32'(es));
    chk("R11 irq", 32'(irq), 32'(es != 0));
    wr(12'h000, 32'h7f);
    m_st[mtx] = exp_word(m_st[mtx], m_st[mtx][31:16], s);
    mtx = (m_st[mtx][13] || mtx == TN - 1) ? 0 : mtx + 1;
  endtask

  task automatic do_rx();
    logic [8:0] s;
    logic [15:0] l;
    logic [6:0] es;
    chk("R6 rx_rdy", 32'(rx_rdy), 32'd1);
    chk("R5 rx_addr", rx_addr, m_ad[mrx]);
    s = 9'($urandom); l = 16'($urandom);
    rx_stat = s; rx_len = l; rx_done = 1;
    cyc();
    rx_done = 0;
    rd(12'h400 + 12'(8 * mrx), rv);
    chk("R6 rx writeback", rv, exp_word(m_st[mrx], l, s));
    es = exp_rx_src(m_st[mrx], s);
    rd(12'h000, rv);
    chk("R9 rx source", rv, 32'(es));
    wr(12'h000, 32'h7f);
    m_st[mrx] = exp_word(m_st[mrx], l, s);
    arm_rx(mrx);
    mrx = m_st[mrx][13] ? TN : mrx + 1;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    chk("R12 reset tx_req", 32'(tx_req), 0);
    chk("R12 reset rx_rdy", 32'(rx_rdy), 0);
    chk("R11 reset irq", 32'(irq), 0);
    rd(12'h000, rv); chk("R1 reset source", rv, 0);
    rd(12'h004, rv); chk("R1 reset mask", rv, 0);
    rd(12'h008, rv); chk("R2 reset count", rv, 64);
    rd(12'h00c, rv); chk("R1 unmapped", rv, 0);
    wr(12'h008, 200);
    rd(12'h008, rv); chk("R2 clamp", rv, 128);
    wr(12'h008, TN);
    rd(12'h008, rv); chk("R2 count", rv, TN);

    for (int i = 0; i < TN + 3; i++) begin
      m_ad[i] = 32'h1000 + 32'(i) * 32'h600;
      wr(12'h404 + 12'(8 * i), m_ad[i]);
      if (i < TN) wset(i, {16'($urandom), 16'h4000});
      else arm_rx(i);
    end
    rd(12'h404, rv); chk("R1 address word", rv, m_ad[0]);
    wr(12'h004, 32'h7f);

    arm_tx(1);
    tx_en = 1;
    repeat (8) cyc();
    chk("R3 no skip", 32'(tx_req), 0);
    arm_tx(0);
    do_tx();
    for (int it = 0; it < 40; it++) begin
      if (!m_st[mtx][15]) arm_tx(mtx);
      do_tx();
    end

    if (mtx == 0) begin arm_tx(0); do_tx(); end
    tx_en = 0;
    cyc();
    chk("R12 tx_req off", 32'(tx_req), 0);
    arm_tx(0);
    tx_en = 1;
    mtx = 0;
    do_tx();

    tx_ctl_done = 1; cyc(); tx_ctl_done = 0;
    rd(12'h000, rv); chk("R10 ctl source", rv, 32'h20);
    wr(12'h000, 32'h20);

    rx_en = 1;
    cyc();
    for (int it = 0; it < 30; it++) do_rx();

    wset(mrx, m_st[mrx] & ~32'h8000);
    chk("R7 rx_rdy low", 32'(rx_rdy), 0);
    rx_stat = 9'h1ff; rx_len = 16'hffff; rx_done = 1;
    cyc();
    rx_done = 0;
    rd(12'h000, rv); chk("R7 busy source", rv, 32'h10);
    rd(12'h400 + 12'(8 * mrx), rv); chk("R7 descriptor kept", rv, m_st[mrx]);
    wr(12'h000, 32'h7f);
    arm_rx(mrx);
    do_rx();

    if (mrx == TN) do_rx();
    rx_en = 0;
    cyc();
    chk("R12 rx_rdy off", 32'(rx_rdy), 0);
    rx_en = 1;
    mrx = TN;
    cyc();
    do_rx();

    wr(12'h004, 0);
    tx_ctl_done = 1; cyc(); tx_ctl_done = 0;
    chk("R11 masked irq", 32'(irq), 0);
    wr(12'h004, 32'h20);
    chk("R11 unmasked irq", 32'(irq), 1);
    host_we = 1; host_addr = 12'h000; host_wdata = 32'h20; tx_ctl_done = 1;
    cyc();
    host_we = 0; tx_ctl_done = 0;
    rd(12'h000, rv); chk("R11 set beats clear", rv, 32'h20);
    wr(12'h000, 32'h20);
    rd(12'h000, rv); chk("R11 clear", rv, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule